// File: doc/BRIEF.md
# 64-Pin GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O controller for 64 pins. Software on a simple register bus sets each pin's direction. It changes output values through separate write-one-to-set and write-one-to-clear registers, so it never has to do a read-modify-write. It can also read the synchronized level of every pad.

Each pin has two independent enables, one for rising edges and one for falling edges. An enabled edge sets a sticky status bit, and software clears that bit by writing a one to it. A single level-sensitive interrupt stays high while any status bit is set.

Every per-pin function takes two consecutive 32-bit words. Pin n sits in word n/32 at bit n%32. Word pairs are eight bytes apart, with the low word first.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, `pin_out`, `pin_oe`, `irq` and the direction, rising-enable, falling-enable and status registers are all zero.
- R2: Byte offsets follow `8*function + 4*word`, where word 0 holds pins 0..31 and word 1 holds pins 32..63. The function codes are: 0 level, 1 direction, 2 output set, 3 output clear, 4 rising enable, 5 falling enable, 6 status.
- R3: Writing 1 to an output-set bit drives that pin's `pin_out` high, and writing 1 to an output-clear bit drives it low. Zero bits leave their pins as they were. Both of these registers read as zero.
- R4: The direction register is read/write and drives `pin_oe` directly. A 1 makes the pin an output.
- R5: The level register returns the pad input after a two-flop synchronizer, for every pin including outputs. A pad change made before clock edge k is returned by a read strobe sampled at edge k+2 or later, but not by one sampled at edge k+1.
- R6: A rising edge sets a pin's status bit only if its rising enable is 1, and a falling edge does so only if its falling enable is 1. With both enables set, either edge sets the bit.
- R7: Status bits are sticky. Writing 1 clears a bit and writing 0 leaves it unchanged.
- R8: When a new enabled edge and a write-one-to-clear of the same status bit fall in the same cycle, the bit stays set.
- R9: `irq` is high exactly while any status bit in either word is set.
- R10: Reads of an unmapped or misaligned offset (function code 7 or above, or address bits [1:0] nonzero) return zero. Writes to such offsets, and writes to the level register, change nothing.
- R11: `bus_rdata` holds the addressed word from the clock edge that samples `bus_rd` until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 64 | Asynchronous pad inputs |
| pin_out | output | 64 | Output value per pin |
| pin_oe | output | 64 | Output enable per pin (1 = drive) |
| irq | output | 1 | Level interrupt, high while any status bit is set |

## Verification
The output registers are tried with set and clear patterns in both words, including an all-zero write. This shows a true one-hot set/clear apart from a plain overwrite.

Edge detection is driven with a rising pulse on a rising-only pin and a falling pulse on a falling-only pin, plus both directions on a pin with both enables set. This separates each enable's effect and shows whether the word is chosen correctly.

A level read taken one cycle after a pad change, and another taken two cycles after, pin down the synchronizer depth. A status clear timed to land on the same edge as a fresh edge shows which of the two has priority.

// File: rtl/gpio_pkg.sv
`timescale 1ns/1ps
package gpio_pkg;
    // function codes: offset = 8*code + 4*word
    localparam int FN_LEVEL  = 0;
    localparam int FN_DIR    = 1;
    localparam int FN_SET    = 2;
    localparam int FN_CLR    = 3;
    localparam int FN_RISE   = 4;
    localparam int FN_FALL   = 5;
    localparam int FN_STATUS = 6;
    localparam int FN_COUNT  = 7;
endpackage

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pad_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] sync;
        logic [WIDTH-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = pad_i;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.sync;
    assign rise_o  = st_q.sync & ~st_q.prev;
    assign fall_o  = ~st_q.sync & st_q.prev;

    // R5: the synchronized level is the pad value from two edges earlier
    a_r5_two_stage: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n, 2) |-> (level_o == $past(pad_i, 2)));
endmodule

// File: rtl/gpio_edge_status.sv
`timescale 1ns/1ps
module gpio_edge_status #(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rise_i,
    input  logic [WIDTH-1:0] fall_i,
    input  logic [WIDTH-1:0] rise_en_i,
    input  logic [WIDTH-1:0] fall_en_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] status_o
);
    typedef struct packed {
        logic [WIDTH-1:0] status;
    } stat_t;

    stat_t st_d, st_q;
    logic [WIDTH-1:0] hit;

    always_comb begin
        hit         = (rise_i & rise_en_i) | (fall_i & fall_en_i);
        st_d        = st_q;
        // a fresh edge outranks a clear on the same bit
        st_d.status = (st_q.status & ~clr_i) | hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.status;

    // R6: a bit only becomes set where an enabled edge was seen
    a_r6_set_only_by_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o & ~$past(status_o) & ~$past(hit)) == '0);
    // R7: bits not being cleared stay set
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & $past(status_o & ~clr_i)) == $past(status_o & ~clr_i)));
    // R8: an edge always lands, even under a clear
    a_r8_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & $past(hit)) == $past(hit)));
endmodule

// File: rtl/gpio_regfile.sv
`timescale 1ns/1ps
module gpio_regfile
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 64,
    parameter int WORD_W   = 32,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [WORD_W-1:0]   bus_wdata,
    input  logic                bus_rd,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] level_i,
    input  logic [NUM_PINS-1:0] status_i,
    output logic [NUM_PINS-1:0] dir_o,
    output logic [NUM_PINS-1:0] out_o,
    output logic [NUM_PINS-1:0] rise_en_o,
    output logic [NUM_PINS-1:0] fall_en_o,
    output logic [NUM_PINS-1:0] status_clr_o
);
    localparam int NUM_WORDS = NUM_PINS / WORD_W;
    localparam int WSEL_W    = $clog2(NUM_WORDS);
    localparam int IDX_W     = ADDR_W - 2;
    localparam int FN_W      = IDX_W - WSEL_W;

    typedef struct packed {
        logic [NUM_PINS-1:0] dir;
        logic [NUM_PINS-1:0] out;
        logic [NUM_PINS-1:0] rise_en;
        logic [NUM_PINS-1:0] fall_en;
        logic [WORD_W-1:0]   rdata;
    } regs_t;

    regs_t st_d, st_q;

    logic [WSEL_W-1:0]   word_sel;
    logic [FN_W-1:0]     fn;
    logic                aligned;
    logic                mapped;
    logic [NUM_PINS-1:0] lane_mask;
    logic [NUM_PINS-1:0] lane_data;
    logic                wr_dir, wr_set, wr_clr, wr_rise, wr_fall, wr_stat;
    logic [NUM_PINS-1:0] rd_vec;
    logic [WORD_W-1:0]   rd_word;

    always_comb begin
        word_sel  = bus_addr[WSEL_W+1:2];
        fn        = bus_addr[ADDR_W-1:WSEL_W+2];
        aligned   = (bus_addr[1:0] == 2'b00);
        mapped    = aligned && (int'(fn) < FN_COUNT);
        lane_mask = '0;
        lane_data = '0;
        for (int h = 0; h < NUM_WORDS; h++) begin
            if (word_sel == WSEL_W'(h)) begin
                lane_mask[h*WORD_W +: WORD_W] = '1;
                lane_data[h*WORD_W +: WORD_W] = bus_wdata;
            end
        end

        wr_dir  = bus_wr && aligned && (fn == FN_W'(FN_DIR));
        wr_set  = bus_wr && aligned && (fn == FN_W'(FN_SET));
        wr_clr  = bus_wr && aligned && (fn == FN_W'(FN_CLR));
        wr_rise = bus_wr && aligned && (fn == FN_W'(FN_RISE));
        wr_fall = bus_wr && aligned && (fn == FN_W'(FN_FALL));
        wr_stat = bus_wr && aligned && (fn == FN_W'(FN_STATUS));

        unique case (int'(fn))
            FN_LEVEL:  rd_vec = level_i;
            FN_DIR:    rd_vec = st_q.dir;
            FN_RISE:   rd_vec = st_q.rise_en;
            FN_FALL:   rd_vec = st_q.fall_en;
            FN_STATUS: rd_vec = status_i;
            default:   rd_vec = '0;
        endcase
        rd_word = mapped ? rd_vec[word_sel*WORD_W +: WORD_W] : '0;

        st_d = st_q;
        if (wr_dir)  st_d.dir     = (st_q.dir & ~lane_mask) | lane_data;
        if (wr_rise) st_d.rise_en = (st_q.rise_en & ~lane_mask) | lane_data;
        if (wr_fall) st_d.fall_en = (st_q.fall_en & ~lane_mask) | lane_data;
        if (wr_set)  st_d.out     = st_q.out | lane_data;
        if (wr_clr)  st_d.out     = st_q.out & ~lane_data;
        if (bus_rd)  st_d.rdata   = rd_word;

        status_clr_o = wr_stat ? lane_data : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dir_o     = st_q.dir;
    assign out_o     = st_q.out;
    assign rise_en_o = st_q.rise_en;
    assign fall_en_o = st_q.fall_en;
    assign bus_rdata = st_q.rdata;

    // R3: set bits go high, clear bits go low, on the next edge
    a_r3_set_high: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((out_o & $past(lane_data)) == $past(lane_data)));
    a_r3_clr_low: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((out_o & $past(lane_data)) == '0));
    // R10: unmapped reads return zero
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !mapped) |=> (bus_rdata == '0));
    // R10: a write outside the config registers leaves them alone
    a_r10_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !mapped) |=> ($stable(dir_o) && $stable(out_o) && $stable(rise_en_o) && $stable(fall_en_o)));
endmodule

// File: rtl/gpio_edge_ctrl.sv
`timescale 1ns/1ps
module gpio_edge_ctrl #(
    parameter int NUM_PINS = 64,
    parameter int WORD_W   = 32,
    parameter int ADDR_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [WORD_W-1:0]   bus_wdata,
    input  logic                bus_rd,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);
    logic [NUM_PINS-1:0] level, rise, fall;
    logic [NUM_PINS-1:0] rise_en, fall_en, clr, status;

    gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk(clk), .rst_n(rst_n), .pad_i(pin_in),
        .level_o(level), .rise_o(rise), .fall_o(fall)
    );

    gpio_edge_status #(.WIDTH(NUM_PINS)) u_status (
        .clk(clk), .rst_n(rst_n), .rise_i(rise), .fall_i(fall),
        .rise_en_i(rise_en), .fall_en_i(fall_en), .clr_i(clr),
        .status_o(status)
    );

    gpio_regfile #(.NUM_PINS(NUM_PINS), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .level_i(level), .status_i(status), .dir_o(pin_oe), .out_o(pin_out),
        .rise_en_o(rise_en), .fall_en_o(fall_en), .status_clr_o(clr)
    );

    assign irq = |status;

    // R9: a set status bit that is not cleared keeps irq high next cycle
    a_r9_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~clr) != '0) |=> irq);
endmodule

// File: tb/test_gpio_edge_ctrl.sv
`timescale 1ns/1ps
module test_gpio_edge_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [63:0] pin_in = '0;
    logic [63:0] pin_out, pin_oe;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    gpio_edge_ctrl i_gpio_edge_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // driver: issue a read and queue its expected word
    task automatic do_read(input logic [7:0] a, input logic [31:0] exp, input string req);
        bus_addr = a; bus_rd = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(req);
        @(negedge clk);
        bus_rd = 1'b0;
        @(negedge clk);
    endtask

    always @(posedge clk) rd_seen <= bus_rd;

    // monitor: R11 read data is valid after the sampling edge
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check({t, " R11"}, {32'h0, bus_rdata}, {32'h0, e});
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R11: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        check("R1 pin_out", pin_out, 64'h0);
        check("R1 pin_oe", pin_oe, 64'h0);
        check("R1 irq", {63'h0, irq}, 64'h0);
        do_read(8'h08, 32'h0, "R1 dir lo");
        do_read(8'h20, 32'h0, "R1 rise lo");
        do_read(8'h2C, 32'h0, "R1 fall hi");
        do_read(8'h34, 32'h0, "R1 status hi");

        // R4/R2 direction in the high word
        do_write(8'h0C, 32'h8000_0001);
        check("R4 R2 pin_oe", pin_oe, 64'h8000_0001_0000_0000);
        do_read(8'h0C, 32'h8000_0001, "R4 dir hi");
        do_read(8'h08, 32'h0, "R2 dir lo untouched");

        // R3 set / clear
        do_write(8'h10, 32'h0000_00F0);
        check("R3 set lo", pin_out, 64'h0000_0000_0000_00F0);
        do_write(8'h14, 32'h0000_0001);
        check("R3 set hi", pin_out, 64'h0000_0001_0000_00F0);
        do_write(8'h18, 32'h0000_0030);
        check("R3 clr lo", pin_out, 64'h0000_0001_0000_00C0);
        do_write(8'h18, 32'h0);
        check("R3 zero clr", pin_out, 64'h0000_0001_0000_00C0);
        do_write(8'h10, 32'h0);
        check("R3 zero set", pin_out, 64'h0000_0001_0000_00C0);
        do_read(8'h10, 32'h0, "R3 set reads zero");
        do_read(8'h1C, 32'h0, "R3 clr reads zero");

        // R5 synchronizer depth, output pin 63 included
        pin_in = 64'hA5A5_0000_0000_3C3C;
        tick(1);
        do_read(8'h00, 32'h0, "R5 one edge old");
        do_read(8'h00, 32'h0000_3C3C, "R5 level lo");
        do_read(8'h04, 32'hA5A5_0000, "R5 level hi");
        pin_in = '0;
        tick(4);

        // R6 rising on pin 0
        do_write(8'h20, 32'h1);
        pin_in[0] = 1'b1;
        tick(3);
        check("R6 R9 rise irq", {63'h0, irq}, 64'h1);
        do_read(8'h30, 32'h1, "R6 rise status");
        do_write(8'h30, 32'h1);
        check("R7 R9 clear irq", {63'h0, irq}, 64'h0);
        pin_in[0] = 1'b0;
        tick(3);
        check("R6 fall ignored", {63'h0, irq}, 64'h0);
        do_read(8'h30, 32'h0, "R6 no fall status");

        // R6 falling on pin 34
        do_write(8'h2C, 32'h4);
        pin_in[34] = 1'b1;
        tick(3);
        check("R6 rise ignored", {63'h0, irq}, 64'h0);
        pin_in[34] = 1'b0;
        tick(3);
        check("R9 hi word irq", {63'h0, irq}, 64'h1);
        do_read(8'h34, 32'h4, "R6 fall status hi");

        // R7 write zero keeps, write one clears
        do_write(8'h34, 32'h0);
        do_read(8'h34, 32'h4, "R7 zero write");
        do_write(8'h34, 32'h4);
        check("R9 irq low", {63'h0, irq}, 64'h0);
        do_read(8'h34, 32'h0, "R7 cleared");

        // R6 both edges on pin 5
        do_write(8'h20, 32'h21);
        do_write(8'h28, 32'h20);
        pin_in[5] = 1'b1;
        tick(3);
        do_read(8'h30, 32'h20, "R6 both rise");
        do_write(8'h30, 32'h20);
        pin_in[5] = 1'b0;
        tick(3);
        do_read(8'h30, 32'h20, "R6 both fall");
        do_write(8'h30, 32'h20);

        // R8 edge and clear on the same edge
        pin_in[5] = 1'b1;
        tick(3);
        pin_in[5] = 1'b0;
        tick(2);
        do_write(8'h30, 32'h20);
        do_read(8'h30, 32'h20, "R8 edge wins");
        do_write(8'h30, 32'h20);
        do_read(8'h30, 32'h0, "R8 plain clear");

        // R10 unmapped, misaligned and level writes
        do_read(8'h38, 32'h0, "R10 code 7");
        do_read(8'h3C, 32'h0, "R10 code 7 hi");
        do_read(8'h0E, 32'h0, "R10 misaligned");
        do_write(8'h00, 32'hFFFF_FFFF);
        do_write(8'h38, 32'hFFFF_FFFF);
        do_write(8'h09, 32'hFFFF_FFFF);
        do_write(8'h12, 32'hFFFF_FFFF);
        check("R10 pin_out", pin_out, 64'h0000_0001_0000_00C0);
        check("R10 pin_oe", pin_oe, 64'h8000_0001_0000_0000);
        do_read(8'h00, 32'h0, "R10 level unchanged");
        do_read(8'h08, 32'h0, "R10 dir lo unchanged");

        tick(2);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule